// File: doc/BRIEF.md
# Programmable raster sync generator

This block turns a pixel clock into the timing strobes a raster display needs. These are horizontal and vertical sync, horizontal and vertical blank, and their composite forms, plus a field flag. Every edge is set by a 12-bit start or end value. Each value is compared against a horizontal count that runs 1 to the line total and a vertical count that runs 1 to the frame total.

The block supports progressive and interlaced scanning. In interlaced scanning the vertical count advances twice per line, in half-line steps. Composite sync can carry equalization and serration pulses, at the line rate or at twice the line rate, inside a programmable vertical window. Four outputs each select their function and polarity from an 11-bit mode word. The timing values arrive already loaded on a flat register bank.

All state is updated on the falling clock edge. A small sequencer gates the counters:
- SEQ_PRIMED: entered by restart; the counters sit at zero.
- SEQ_RUN: the counters advance.
- SEQ_FROZEN: the counters and outputs hold.

Transitions:
- PRIMED to RUN: the first enabled edge.
- RUN to FROZEN: the enable drops.
- FROZEN to RUN: the enable returns.
- Restart forces PRIMED from any state.

Top module: `rsg_top`

## Requirements
- R1: On a falling edge with `restart` high, every output goes to its inactive level and `field_odd` goes high. The next falling edge with the enable set (mode bit 10) produces horizontal count 1 and vertical count 1.
- R2: The horizontal count runs 1..`h_total` and then wraps to 1. Horizontal blank is active for counts 1..`h_blank_end`-1. Horizontal sync is active for counts `h_fp_end`..`h_sync_end`-1.
- R3: In progressive scanning the vertical count steps once per line, at horizontal count 1, and runs 1..`v_total`. Vertical blank is active for lines 1..`v_blank_end`-1 and changes at horizontal count 1. Vertical sync covers lines `v_fp_end`..`v_sync_end`-1 and changes only at horizontal count `h_fp_end`.
- R4: In interlaced scanning (mode bits 4:3 = 00) the vertical count steps at horizontal counts 1 and `h_total`/2+1, and runs 1..2·`v_total`. Half-lines 1..`v_total` form the odd field, and the rest form the even field, numbered from 1 again. Vertical sync may also change at `h_fp_end`+`h_total`/2. `field_odd` is high exactly in the odd field.
- R5: Composite sync is active when horizontal or vertical sync is active. Composite blank is active when horizontal or vertical blank is active.
- R6: When mode bit 9 is 0 and the field line lies in `eqs_start`..`eqs_stop`-1, composite sync is replaced by a pulse train. Let the position be counted within each pulse period. Outside vertical sync, the pulse is active for positions `h_fp_end`..`eq_end`-1 (equalization). During vertical sync, it is active except for positions `h_fp_end`..`serr_end`-1 (serration).
- R7: Mode bits 4:3 set the timing mode, and the pulse period follows from it:
  - 00: interlaced, period `h_total`/2.
  - 01: progressive, period `h_total`/2.
  - 11: progressive, period `h_total`.
  - 10: handled as 11.
- R8: Mode bits 2:0 select what each output carries:
  - Bit 0 = 1: `blank_out` is vertical blank and `hdrv_out` is horizontal blank.
  - Bit 0 = 0: `blank_out` is composite blank, and `hdrv_out` is the horizontal gate (bit 2 = 0) or the cursor (bit 2 = 1).
  - Bit 1 = 1: `sync_out` is vertical sync and `vdrv_out` is horizontal sync.
  - Bit 1 = 0: `sync_out` is composite sync, and `vdrv_out` is the vertical gate (bit 2 = 0) or the line interrupt (bit 2 = 1).
- R9: Mode bits 5, 6, 7 and 8 set the polarity of `blank_out`, `sync_out`, `hdrv_out` and `vdrv_out` in turn. A 0 makes the output active-low and a 1 makes it active-high.
- R10: The horizontal gate is active for counts `hgate_on`..`hgate_off`-1. The vertical gate is active for field lines `vgate_on`..`vgate_off`-1. The cursor is active when both gates are active. The line interrupt is active for field lines `vint_on`..`vint_off`-1.
- R11: With mode bit 10 at 0, the counters and all outputs hold their values on every edge, whatever else the mode word does.
- R12: In progressive scanning `field_odd` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; state changes on its falling edge |
| restart | input | 1 | Synchronous restart, active high |
| mode_word | input | 11 | Output select, timing mode, polarity, pulse insertion disable, enable |
| h_fp_end | input | 12 | Horizontal sync start count |
| h_sync_end | input | 12 | Horizontal sync end count |
| h_blank_end | input | 12 | Horizontal blank end count |
| h_total | input | 12 | Clocks per line (even) |
| v_fp_end | input | 12 | Vertical sync start line |
| v_sync_end | input | 12 | Vertical sync end line |
| v_blank_end | input | 12 | Vertical blank end line |
| v_total | input | 12 | Lines per frame |
| eq_end | input | 12 | Equalization pulse end position |
| serr_end | input | 12 | Serration gap end position |
| eqs_start | input | 12 | First line of pulse insertion window |
| eqs_stop | input | 12 | Line ending the pulse insertion window |
| vint_on | input | 12 | Line interrupt start line |
| vint_off | input | 12 | Line interrupt end line |
| hgate_on | input | 12 | Horizontal gate start count |
| hgate_off | input | 12 | Horizontal gate end count |
| vgate_on | input | 12 | Vertical gate start line |
| vgate_off | input | 12 | Vertical gate end line |
| blank_out | output | 1 | Vertical or composite blank |
| sync_out | output | 1 | Vertical or composite sync |
| hdrv_out | output | 1 | Horizontal blank, horizontal gate or cursor |
| vdrv_out | output | 1 | Horizontal sync, vertical gate or line interrupt |
| field_odd | output | 1 | High in the odd field |

## Verification
The bench targets the first enabled edge after restart: a counter that starts at 0, or that skips count 1, shifts every pulse by a clock. It targets vertical sync, which must switch at the sync start count rather than at line start; a design that used the line boundary would stretch vertical sync by the front porch. It targets interlaced half-line stepping and the field flag, where a wrong midpoint breaks the 90-clock odd field. It also targets the serration/equalization choice and the double-rate period. Freezing with a polarity change pending catches an output stage that keeps reacting to mode bits while the enable is off.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
    localparam int unsigned TW   = 12;
    localparam int unsigned VW   = TW + 1;
    localparam int unsigned NOUT = 4;
    localparam int unsigned MW   = 11;

    typedef enum logic [1:0] {
        SEQ_PRIMED = 2'd0,
        SEQ_RUN    = 2'd1,
        SEQ_FROZEN = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        TM_INTL_DBL = 2'b00,
        TM_PROG_DBL = 2'b01,
        TM_BAD      = 2'b10,
        TM_PROG_SGL = 2'b11
    } tmode_e;

    function automatic logic [VW-1:0] ext(input logic [TW-1:0] x);
        return {1'b0, x};
    endfunction

    function automatic logic in_span(input logic [VW-1:0] v,
                                     input logic [VW-1:0] lo,
                                     input logic [VW-1:0] hi);
        return (v >= lo) && (v < hi);
    endfunction
endpackage

// File: rtl/rsg_seq.sv
module rsg_seq
    import rsg_pkg::*;
(
    input  logic          clk,
    input  logic          restart,
    input  logic          run_en,
    input  logic          intl,
    input  logic [TW-1:0] h_total,
    input  logic [TW-1:0] v_total,
    output seq_state_e    state_q,
    output logic [TW-1:0] hc_q,
    output logic [TW-1:0] hc_n,
    output logic [VW-1:0] fpos_n,
    output logic          fodd_n
);
    seq_state_e    state_n;
    logic [TW-1:0] half_pt;
    logic [VW-1:0] v_limit;
    logic [VW-1:0] vc_q;
    logic [VW-1:0] vc_n;
    logic          vtick;

    assign half_pt = h_total >> 1;
    assign v_limit = intl ? {v_total, 1'b0} : {1'b0, v_total};

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SEQ_PRIMED: if (run_en)  state_n = SEQ_RUN;
            SEQ_RUN:    if (!run_en) state_n = SEQ_FROZEN;
            SEQ_FROZEN: if (run_en)  state_n = SEQ_RUN;
            default:                 state_n = SEQ_PRIMED;
        endcase
    end

    always_comb begin
        hc_n  = hc_q;
        vc_n  = vc_q;
        vtick = 1'b0;
        if (run_en) begin
            if (state_q == SEQ_PRIMED) begin
                hc_n = TW'(1);
                vc_n = VW'(1);
            end else begin
                hc_n  = (hc_q >= h_total) ? TW'(1) : hc_q + TW'(1);
                vtick = (hc_n == TW'(1)) || (intl && (hc_n == half_pt + TW'(1)));
                if (vtick) begin
                    vc_n = (vc_q >= v_limit) ? VW'(1) : vc_q + VW'(1);
                end
            end
        end
    end

    // second field numbered from 1 again
    assign fodd_n = !intl || (vc_n <= ext(v_total));
    assign fpos_n = fodd_n ? vc_n : vc_n - ext(v_total);

    always_ff @(negedge clk) begin
        if (restart) begin
            state_q <= SEQ_PRIMED;
            hc_q    <= '0;
            vc_q    <= '0;
        end else begin
            state_q <= state_n;
            hc_q    <= hc_n;
            vc_q    <= vc_n;
        end
    end
endmodule

// File: rtl/rsg_pulses.sv
module rsg_pulses
    import rsg_pkg::*;
(
    input  logic          clk,
    input  logic          restart,
    input  logic          adv,
    input  logic          intl,
    input  logic          dbl,
    input  logic          eqs_on,
    input  logic [TW-1:0] hc_n,
    input  logic [VW-1:0] fpos_n,
    input  logic [TW-1:0] h_fp_end,
    input  logic [TW-1:0] h_sync_end,
    input  logic [TW-1:0] h_blank_end,
    input  logic [TW-1:0] h_total,
    input  logic [TW-1:0] v_fp_end,
    input  logic [TW-1:0] v_sync_end,
    input  logic [TW-1:0] v_blank_end,
    input  logic [TW-1:0] eq_end,
    input  logic [TW-1:0] serr_end,
    input  logic [TW-1:0] eqs_start,
    input  logic [TW-1:0] eqs_stop,
    input  logic [TW-1:0] vint_on,
    input  logic [TW-1:0] vint_off,
    input  logic [TW-1:0] hgate_on,
    input  logic [TW-1:0] hgate_off,
    input  logic [TW-1:0] vgate_on,
    input  logic [TW-1:0] vgate_off,
    output logic          hblank,
    output logic          hsync,
    output logic          vblank,
    output logic          vsync,
    output logic          cblank,
    output logic          csync,
    output logic          hgate,
    output logic          vgate,
    output logic          cursor,
    output logic          vint
);
    logic [TW-1:0] half_pt;
    logic [TW-1:0] hpos;
    logic          hs_lead;
    logic          vs_q;
    logic          vs_now;
    logic          in_win;
    logic          eq_pulse;
    logic          ser_pulse;

    assign half_pt = h_total >> 1;

    assign hblank = in_span(ext(hc_n), VW'(1), ext(h_blank_end));
    assign hsync  = in_span(ext(hc_n), ext(h_fp_end), ext(h_sync_end));
    assign vblank = in_span(fpos_n, VW'(1), ext(v_blank_end));

    // vertical sync only re-evaluated at a horizontal sync leading edge
    assign hs_lead = adv && ((hc_n == h_fp_end) ||
                             (intl && (hc_n == h_fp_end + half_pt)));
    assign vs_now  = hs_lead ? in_span(fpos_n, ext(v_fp_end), ext(v_sync_end)) : vs_q;
    assign vsync   = vs_now;

    assign hpos      = (dbl && (hc_n > half_pt)) ? hc_n - half_pt : hc_n;
    assign in_win    = eqs_on && in_span(fpos_n, ext(eqs_start), ext(eqs_stop));
    assign eq_pulse  = in_span(ext(hpos), ext(h_fp_end), ext(eq_end));
    assign ser_pulse = !in_span(ext(hpos), ext(h_fp_end), ext(serr_end));

    assign csync  = in_win ? (vs_now ? ser_pulse : eq_pulse) : (hsync || vs_now);
    assign cblank = hblank || vblank;

    assign hgate  = in_span(ext(hc_n), ext(hgate_on), ext(hgate_off));
    assign vgate  = in_span(fpos_n, ext(vgate_on), ext(vgate_off));
    assign cursor = hgate && vgate;
    assign vint   = in_span(fpos_n, ext(vint_on), ext(vint_off));

    always_ff @(negedge clk) begin
        if (restart) begin
            vs_q <= 1'b0;
        end else begin
            vs_q <= vs_now;
        end
    end
endmodule

// File: rtl/rsg_outsel.sv
module rsg_outsel
    import rsg_pkg::*;
(
    input  logic [2:0]      sel,
    input  logic [NOUT-1:0] pol,
    input  logic            hblank,
    input  logic            hsync,
    input  logic            vblank,
    input  logic            vsync,
    input  logic            cblank,
    input  logic            csync,
    input  logic            hgate,
    input  logic            vgate,
    input  logic            cursor,
    input  logic            vint,
    output logic [NOUT-1:0] lvl
);
    logic [NOUT-1:0] act;

    always_comb begin
        act[0] = sel[0] ? vblank : cblank;
        act[1] = sel[1] ? vsync  : csync;
        act[2] = sel[0] ? hblank : (sel[2] ? cursor : hgate);
        act[3] = sel[1] ? hsync  : (sel[2] ? vint   : vgate);
    end

    for (genvar i = 0; i < NOUT; i++) begin : g_pol
        assign lvl[i] = pol[i] ? act[i] : ~act[i];
    end
endmodule

// File: rtl/rsg_top.sv
module rsg_top
    import rsg_pkg::*;
(
    input  logic          clk,
    input  logic          restart,
    input  logic [MW-1:0] mode_word,
    input  logic [TW-1:0] h_fp_end,
    input  logic [TW-1:0] h_sync_end,
    input  logic [TW-1:0] h_blank_end,
    input  logic [TW-1:0] h_total,
    input  logic [TW-1:0] v_fp_end,
    input  logic [TW-1:0] v_sync_end,
    input  logic [TW-1:0] v_blank_end,
    input  logic [TW-1:0] v_total,
    input  logic [TW-1:0] eq_end,
    input  logic [TW-1:0] serr_end,
    input  logic [TW-1:0] eqs_start,
    input  logic [TW-1:0] eqs_stop,
    input  logic [TW-1:0] vint_on,
    input  logic [TW-1:0] vint_off,
    input  logic [TW-1:0] hgate_on,
    input  logic [TW-1:0] hgate_off,
    input  logic [TW-1:0] vgate_on,
    input  logic [TW-1:0] vgate_off,
    output logic          blank_out,
    output logic          sync_out,
    output logic          hdrv_out,
    output logic          vdrv_out,
    output logic          field_odd
);
    logic [2:0]      sel;
    logic [NOUT-1:0] pol;
    tmode_e          tmode;
    logic            eqs_on;
    logic            run_en;
    logic            intl;
    logic            dbl;

    seq_state_e      seq_state;
    logic [TW-1:0]   hc_q;
    logic [TW-1:0]   hc_n;
    logic [VW-1:0]   fpos_n;
    logic            fodd_n;

    logic hblank, hsync, vblank, vsync, cblank, csync, hgate, vgate, cursor, vint;
    logic [NOUT-1:0] lvl;
    logic [NOUT-1:0] out_q;
    logic            odd_q;

    assign sel    = mode_word[2:0];
    assign tmode  = tmode_e'(mode_word[4:3]);
    assign pol    = mode_word[8:5];
    assign eqs_on = !mode_word[9];
    assign run_en = mode_word[10];
    assign intl   = (tmode == TM_INTL_DBL);
    assign dbl    = (tmode == TM_INTL_DBL) || (tmode == TM_PROG_DBL);

    rsg_seq u_seq (
        .clk     (clk),
        .restart (restart),
        .run_en  (run_en),
        .intl    (intl),
        .h_total (h_total),
        .v_total (v_total),
        .state_q (seq_state),
        .hc_q    (hc_q),
        .hc_n    (hc_n),
        .fpos_n  (fpos_n),
        .fodd_n  (fodd_n)
    );

    rsg_pulses u_pulses (
        .clk         (clk),
        .restart     (restart),
        .adv         (run_en),
        .intl        (intl),
        .dbl         (dbl),
        .eqs_on      (eqs_on),
        .hc_n        (hc_n),
        .fpos_n      (fpos_n),
        .h_fp_end    (h_fp_end),
        .h_sync_end  (h_sync_end),
        .h_blank_end (h_blank_end),
        .h_total     (h_total),
        .v_fp_end    (v_fp_end),
        .v_sync_end  (v_sync_end),
        .v_blank_end (v_blank_end),
        .eq_end      (eq_end),
        .serr_end    (serr_end),
        .eqs_start   (eqs_start),
        .eqs_stop    (eqs_stop),
        .vint_on     (vint_on),
        .vint_off    (vint_off),
        .hgate_on    (hgate_on),
        .hgate_off   (hgate_off),
        .vgate_on    (vgate_on),
        .vgate_off   (vgate_off),
        .hblank      (hblank),
        .hsync       (hsync),
        .vblank      (vblank),
        .vsync       (vsync),
        .cblank      (cblank),
        .csync       (csync),
        .hgate       (hgate),
        .vgate       (vgate),
        .cursor      (cursor),
        .vint        (vint)
    );

    rsg_outsel u_outsel (
        .sel    (sel),
        .pol    (pol),
        .hblank (hblank),
        .hsync  (hsync),
        .vblank (vblank),
        .vsync  (vsync),
        .cblank (cblank),
        .csync  (csync),
        .hgate  (hgate),
        .vgate  (vgate),
        .cursor (cursor),
        .vint   (vint),
        .lvl    (lvl)
    );

    always_ff @(negedge clk) begin
        if (restart) begin
            out_q <= ~pol;
            odd_q <= 1'b1;
        end else if (run_en) begin
            out_q <= lvl;
            odd_q <= fodd_n;
        end
    end

    assign blank_out = out_q[0];
    assign sync_out  = out_q[1];
    assign hdrv_out  = out_q[2];
    assign vdrv_out  = out_q[3];
    assign field_odd = odd_q;
endmodule

// File: rtl/rsg_chk.sv
module rsg_chk
    import rsg_pkg::*;
(
    input logic            clk,
    input logic            restart,
    input logic            run_en,
    input logic            intl,
    input seq_state_e      state_q,
    input logic [TW-1:0]   hc_q,
    input logic [TW-1:0]   h_total,
    input logic [NOUT-1:0] outs,
    input logic            odd
);
    // R2
    hc_step_chk: assert property (@(negedge clk) disable iff (restart)
        (state_q == SEQ_RUN && run_en && hc_q < h_total) |=> (hc_q == $past(hc_q) + TW'(1)));

    // R2
    hc_wrap_chk: assert property (@(negedge clk) disable iff (restart)
        (state_q == SEQ_RUN && run_en && hc_q >= h_total) |=> (hc_q == TW'(1)));

    // R1
    first_edge_chk: assert property (@(negedge clk) disable iff (restart)
        (state_q == SEQ_PRIMED && run_en) |=> (hc_q == TW'(1) && state_q == SEQ_RUN));

    // R11
    freeze_hold_chk: assert property (@(negedge clk) disable iff (restart)
        (!run_en) |=> ($stable(outs) && $stable(odd) && $stable(hc_q)));

    // R12
    prog_odd_chk: assert property (@(negedge clk) disable iff (restart)
        (run_en && !intl) |=> odd);
endmodule

bind rsg_top rsg_chk u_chk (
    .clk     (clk),
    .restart (restart),
    .run_en  (run_en),
    .intl    (intl),
    .state_q (seq_state),
    .hc_q    (hc_q),
    .h_total (h_total),
    .outs    (out_q),
    .odd     (odd_q)
);

// File: tb/rsg_top_tb.sv
`timescale 1ns/1ps
module rsg_top_tb;
    logic        clk = 1'b0;
    logic        restart = 1'b1;
    logic [10:0] mode = '0;
    logic [11:0] hfp, hse, hbe, ht, vfp, vse, vbe, vt, eqe, sre, ess, esp;
    logic [11:0] vion, viof, hgon, hgof, vgon, vgof;
    logic        blank_out, sync_out, hdrv_out, vdrv_out, field_odd;

    int n_chk = 0;
    int n_bad = 0;

    int          m_hc, m_vc;
    bit          m_vs, m_primed;
    logic [3:0]  e_lvl;
    logic        e_odd;

    always #2 clk = ~clk;

    rsg_top u_dut (
        .clk(clk), .restart(restart), .mode_word(mode),
        .h_fp_end(hfp), .h_sync_end(hse), .h_blank_end(hbe), .h_total(ht),
        .v_fp_end(vfp), .v_sync_end(vse), .v_blank_end(vbe), .v_total(vt),
        .eq_end(eqe), .serr_end(sre), .eqs_start(ess), .eqs_stop(esp),
        .vint_on(vion), .vint_off(viof), .hgate_on(hgon), .hgate_off(hgof),
        .vgate_on(vgon), .vgate_off(vgof),
        .blank_out(blank_out), .sync_out(sync_out), .hdrv_out(hdrv_out),
        .vdrv_out(vdrv_out), .field_odd(field_odd)
    );

    function automatic logic [10:0] mk_mode(input bit en, input bit eq_off,
                                            input logic [3:0] pol,
                                            input logic [1:0] tm, input logic [2:0] sel);
        return {en, eq_off, pol, tm, sel};
    endfunction

    function automatic bit sp(input int v, input int lo, input int hi);
        return (v >= lo) && (v < hi);
    endfunction

    task automatic set_timing();
        ht = 20; hfp = 3; hse = 7; hbe = 10;
        vt = 9;  vfp = 2; vse = 4; vbe = 5;
        eqe = 5; sre = 8; ess = 1; esp = 6;
        vion = 6; viof = 8; hgon = 12; hgof = 16; vgon = 3; vgof = 7;
    endtask

    // expected behaviour written from the requirements
    task automatic model_step();
        int half, vlim, fpos, hp;
        bit intl, dbl, odd, hb, hs, vb, win, cs;
        logic [3:0] act;
        logic [3:0] pol;
        pol = mode[8:5];
        if (restart) begin
            m_primed = 1; m_hc = 0; m_vc = 0; m_vs = 0;
            e_lvl = ~pol; e_odd = 1'b1;
            return;
        end
        if (!mode[10]) return;
        intl = (mode[4:3] == 2'b00);
        dbl  = !mode[4];
        half = int'(ht) / 2;
        vlim = intl ? 2 * int'(vt) : int'(vt);
        if (m_primed) begin
            m_hc = 1; m_vc = 1; m_primed = 0;
        end else begin
            m_hc = (m_hc >= int'(ht)) ? 1 : m_hc + 1;
            if (m_hc == 1 || (intl && m_hc == half + 1))
                m_vc = (m_vc >= vlim) ? 1 : m_vc + 1;
        end
        odd  = !intl || (m_vc <= int'(vt));
        fpos = odd ? m_vc : m_vc - int'(vt);
        if (m_hc == int'(hfp) || (intl && m_hc == int'(hfp) + half))
            m_vs = sp(fpos, vfp, vse);
        hb = sp(m_hc, 1, hbe);
        hs = sp(m_hc, hfp, hse);
        vb = sp(fpos, 1, vbe);
        hp = (dbl && m_hc > half) ? m_hc - half : m_hc;
        win = !mode[9] && sp(fpos, ess, esp);
        if (win) cs = m_vs ? !sp(hp, hfp, sre) : sp(hp, hfp, eqe);
        else     cs = hs || m_vs;
        act[0] = mode[0] ? vb : (hb || vb);
        act[1] = mode[1] ? m_vs : cs;
        act[2] = mode[0] ? hb : (mode[2] ? (sp(m_hc, hgon, hgof) && sp(fpos, vgon, vgof))
                                         : sp(m_hc, hgon, hgof));
        act[3] = mode[1] ? hs : (mode[2] ? sp(fpos, vion, viof) : sp(fpos, vgon, vgof));
        for (int i = 0; i < 4; i++) e_lvl[i] = pol[i] ? act[i] : !act[i];
        e_odd = odd;
    endtask

    task automatic cyc(input string tag);
        logic [3:0] got;
        @(negedge clk);
        #1;
        model_step();
        got = {vdrv_out, hdrv_out, sync_out, blank_out};
        n_chk++;
        if (got !== e_lvl || field_odd !== e_odd) begin
            n_bad++;
            $display("FAIL %s t=%0t: outs=%b odd=%b expected outs=%b odd=%b",
                     tag, $time, got, field_odd, e_lvl, e_odd);
        end
    endtask

    task automatic chk1(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic do_restart(input string tag);
        restart = 1'b1;
        cyc(tag);
        restart = 1'b0;
    endtask

    task automatic t_reset();
        set_timing();
        mode = mk_mode(0, 1, 4'b0000, 2'b11, 3'b111);
        do_restart("R1");
        chk1("R1", {vdrv_out, hdrv_out, sync_out, blank_out}, 4'b1111);
        chk1("R1", field_odd, 1);
        run("R1", 3);
        mode = mk_mode(1, 1, 4'b0000, 2'b11, 3'b111);
        cyc("R1");
        chk1("R1", hdrv_out, 0);
        mode = mk_mode(1, 1, 4'b1111, 2'b11, 3'b111);
        do_restart("R9");
        chk1("R9", {vdrv_out, hdrv_out, sync_out, blank_out}, 4'b0000);
    endtask

    task automatic t_separate();
        int hs_n = 0, hb_n = 0, vs_n = 0, ev_n = 0;
        set_timing();
        mode = mk_mode(1, 1, 4'b0000, 2'b11, 3'b111);
        do_restart("R1");
        for (int i = 1; i <= 180; i++) begin
            cyc("R3");
            if (i <= 20 && !vdrv_out) hs_n++;
            if (i <= 20 && !hdrv_out) hb_n++;
            if (!sync_out) vs_n++;
            if (!field_odd) ev_n++;
        end
        chk1("R2", hs_n, 4);
        chk1("R2", hb_n, 9);
        chk1("R3", vs_n, 40);
        chk1("R12", ev_n, 0);
        run("R2", 180);
    endtask

    task automatic t_composite();
        set_timing();
        mode = mk_mode(1, 1, 4'b0000, 2'b11, 3'b000);
        do_restart("R5");
        run("R5", 360);
    endtask

    task automatic t_eqser();
        set_timing();
        mode = mk_mode(1, 0, 4'b0000, 2'b01, 3'b110);
        do_restart("R6");
        run("R6", 360);
        mode = mk_mode(1, 0, 4'b0000, 2'b11, 3'b110);
        do_restart("R7");
        run("R7", 360);
        mode = mk_mode(1, 0, 4'b0000, 2'b10, 3'b110);
        do_restart("R7");
        run("R7", 200);
    endtask

    task automatic t_interlace();
        int odd_n = 0;
        set_timing();
        vfp = 3; vse = 7; vbe = 9; ess = 1; esp = 9;
        mode = mk_mode(1, 1, 4'b0000, 2'b00, 3'b111);
        do_restart("R4");
        for (int i = 1; i <= 180; i++) begin
            cyc("R4");
            if (field_odd) odd_n++;
        end
        chk1("R4", odd_n, 90);
        run("R4", 180);
        mode = mk_mode(1, 0, 4'b0000, 2'b00, 3'b000);
        do_restart("R6");
        run("R6", 360);
    endtask

    task automatic t_polarity();
        set_timing();
        mode = mk_mode(1, 1, 4'b1111, 2'b11, 3'b111);
        do_restart("R9");
        run("R9", 200);
        mode = mk_mode(1, 0, 4'b1010, 2'b01, 3'b000);
        do_restart("R9");
        run("R9", 200);
    endtask

    task automatic t_gates();
        set_timing();
        mode = mk_mode(1, 1, 4'b1100, 2'b11, 3'b100);
        do_restart("R10");
        run("R10", 360);
        mode = mk_mode(1, 1, 4'b0000, 2'b11, 3'b000);
        do_restart("R8");
        run("R8", 200);
        mode = mk_mode(1, 1, 4'b0000, 2'b11, 3'b101);
        do_restart("R8");
        run("R8", 200);
        mode = mk_mode(1, 1, 4'b0000, 2'b11, 3'b010);
        do_restart("R8");
        run("R8", 200);
    endtask

    task automatic t_freeze();
        logic [4:0] snap;
        set_timing();
        mode = mk_mode(1, 1, 4'b0000, 2'b11, 3'b111);
        do_restart("R11");
        run("R11", 45);
        mode = mk_mode(0, 1, 4'b0000, 2'b11, 3'b111);
        run("R11", 10);
        snap = {field_odd, vdrv_out, hdrv_out, sync_out, blank_out};
        mode = mk_mode(0, 0, 4'b1111, 2'b00, 3'b000);
        run("R11", 20);
        chk1("R11", {field_odd, vdrv_out, hdrv_out, sync_out, blank_out}, snap);
        mode = mk_mode(1, 1, 4'b0000, 2'b11, 3'b111);
        run("R11", 200);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        set_timing();
        t_reset();
        t_separate();
        t_composite();
        t_eqser();
        t_interlace();
        t_polarity();
        t_gates();
        t_freeze();
        finish_up();
    end

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end
endmodule